// File: doc/BRIEF.md
# Token Packet Classifier with CRC5 Check

This block sits behind a serial receiver that has already removed stuffed bits and assembled bytes. Each packet is framed by a one-cycle start marker and a one-cycle end marker, with the bytes arriving one at a time between them. The first byte is the packet identifier. The block checks it for internal consistency and sorts the packet into a class: token, frame marker, data, handshake or special.

For token packets the block pulls out the device address and endpoint number. For frame-marker packets it pulls out the 11-bit frame count. For both of these it checks the 5-bit CRC that closes the packet. Data packets are only classified. Their payload checksum is left to a later stage.

One cycle after the end marker the block gives its verdict. A clean packet produces a single valid pulse. A faulty packet produces one or more error pulses instead: identifier error, CRC error or length error. Downstream protocol logic uses this verdict to decide whether it may answer the packet.

Top module: `pkt_token_decoder`

## Requirements
- R1: After reset, `dec_valid`, `err_pid`, `err_crc` and `err_len` are 0, `dec_class` is 0, and `dec_addr`, `dec_endp` and `dec_frame` are 0.
- R2: The identifier's upper nibble must equal the bitwise inverse of its lower nibble. When it does not, `err_pid` pulses, `dec_class` reads 0 and no valid pulse is given.
- R3: `dec_pid` shows the lower nibble of the identifier. `dec_class` shows the class, encoded as follows. Lower nibble 1, 9 or D gives token, class 1. Lower nibble 5 gives frame marker, class 2. Lower nibble 3 or B gives data, class 3. Lower nibble 2, A or E gives handshake, class 4. Lower nibble C gives special, class 5. Any other lower nibble sets `err_pid`, even when the complement check passes.
- R4: For a clean token, `dec_addr` takes bits 6..0 of byte 1. `dec_endp` takes {byte 2 bits 2..0, byte 1 bit 7}.
- R5: For a clean frame marker, `dec_frame` takes {byte 2 bits 2..0, byte 1}.
- R6: The CRC covers bytes 1 and 2 of a token or frame-marker packet. Each byte is fed least significant bit first. The 5-bit register starts at 11111. For each bit it shifts left, and when (input bit XOR old bit 4) is 1 it XORs in 00101. Any final value other than 01100 raises `err_crc`.
- R7: A token or frame-marker packet that does not hold exactly three bytes raises `err_len` and never `err_crc`.
- R8: A handshake packet with any byte after the identifier raises `err_len`. A packet with no bytes at all raises `err_len` only.
- R9: The verdict appears in the cycle after the end marker and lasts one cycle. `dec_valid` pulses only when no error flag is set.
- R10: Data and special packets of any non-zero length are accepted. Their later bytes raise neither `err_crc` nor `err_len`.
- R11: `dec_addr` and `dec_endp` change only on a clean token. `dec_frame` changes only on a clean frame marker. Every other packet leaves them as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | One-cycle start marker; carries no byte |
| byte_valid | input | 1 | `byte_data` holds the next packet byte |
| byte_data | input | 8 | Received byte |
| pkt_end | input | 1 | One-cycle end marker; carries no byte |
| dec_valid | output | 1 | Clean-packet pulse |
| dec_class | output | 3 | Packet class code |
| dec_pid | output | 4 | Identifier type nibble |
| dec_addr | output | 7 | Token device address |
| dec_endp | output | 4 | Token endpoint number |
| dec_frame | output | 11 | Frame count |
| err_pid | output | 1 | Identifier error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_len | output | 1 | Length error pulse |

## Verification
Every result is registered once, on the clock edge that accepts the end marker. Class, type, field outputs and all four pulses are therefore due exactly one cycle after the end marker is driven. The bench drives inputs on the falling edge and raises the end marker for one cycle. It reads every output on the next falling edge, then reads again one cycle later to confirm that the pulses have dropped. The CRC values the bench uses are found by searching all 32 candidates for the one that leaves the stated residue.

// File: rtl/pkt_dec_pkg.sv
package pkt_dec_pkg;
   typedef enum logic [2:0] {
      CLS_NONE    = 3'd0,
      CLS_TOKEN   = 3'd1,
      CLS_FRAME   = 3'd2,
      CLS_DATA    = 3'd3,
      CLS_HSHAKE  = 3'd4,
      CLS_SPECIAL = 3'd5
   } pkt_class_e;

   localparam int BYTE_W = 8;
   localparam int NIB_W  = 4;
endpackage

// File: rtl/pid_classify.sv
module pid_classify
   import pkt_dec_pkg::*;
(
   input  logic [BYTE_W-1:0] pid_byte,
   output logic              pid_ok,
   output pkt_class_e        pid_class
);
   logic [NIB_W-1:0] kind;
   logic             cpl_ok;
   pkt_class_e       table_cls;

   assign kind   = pid_byte[NIB_W-1:0];
   assign cpl_ok = (pid_byte[BYTE_W-1:NIB_W] == ~kind);

   always_comb begin
      unique case (kind)
         4'h1, 4'h9, 4'hD: table_cls = CLS_TOKEN;
         4'h5:             table_cls = CLS_FRAME;
         4'h3, 4'hB:       table_cls = CLS_DATA;
         4'h2, 4'hA, 4'hE: table_cls = CLS_HSHAKE;
         4'hC:             table_cls = CLS_SPECIAL;
         default:          table_cls = CLS_NONE;
      endcase
   end

   assign pid_ok    = cpl_ok && (table_cls != CLS_NONE);
   assign pid_class = pid_ok ? table_cls : CLS_NONE;
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
   parameter int             CRC_W  = 5,
   parameter logic [CRC_W-1:0] POLY = 5'b00101,
   parameter int             DATA_W = 8
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc_out
);
   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = crc_in;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb = data[i] ^ stage[i][CRC_W-1];
      assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[DATA_W];
endmodule

// File: rtl/pkt_token_decoder.sv
module pkt_token_decoder
   import pkt_dec_pkg::*;
#(
   parameter int               ADDR_W  = 7,
   parameter int               ENDP_W  = 4,
   parameter int               FRAME_W = 11,
   parameter int               CRC_W   = 5,
   parameter logic [CRC_W-1:0] CRC_POLY    = 5'b00101,
   parameter logic [CRC_W-1:0] CRC_INIT    = 5'b11111,
   parameter logic [CRC_W-1:0] CRC_RESIDUE = 5'b01100,
   parameter int               FIELD_BYTES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pkt_start,
   input  logic         byte_valid,
   input  logic [7:0]   byte_data,
   input  logic         pkt_end,
   output logic         dec_valid,
   output logic [2:0]   dec_class,
   output logic [3:0]   dec_pid,
   output logic [6:0]   dec_addr,
   output logic [3:0]   dec_endp,
   output logic [10:0]  dec_frame,
   output logic         err_pid,
   output logic         err_crc,
   output logic         err_len
);
   localparam int PAY_W   = FIELD_BYTES * BYTE_W;
   localparam int FULL_N  = FIELD_BYTES + 1;
   localparam int CNT_MAX = FULL_N + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int HI_W    = FRAME_W - BYTE_W;

   if (ADDR_W + ENDP_W + CRC_W != PAY_W) begin : g_bad_tok
      $error("token fields do not fill the payload bytes");
   end
   if (FRAME_W + CRC_W != PAY_W) begin : g_bad_frame
      $error("frame fields do not fill the payload bytes");
   end
   if (ADDR_W != 7 || ENDP_W != 4 || FRAME_W != 11) begin : g_bad_ports
      $error("field widths must match the port widths");
   end
   if (FIELD_BYTES != 2) begin : g_bad_bytes
      $error("payload capture supports two field bytes");
   end

   // Capture state
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] pid_q, b1_q, b2_q;
   logic [CRC_W-1:0]  crc_q, crc_nx;

   crc_byte_step #(.CRC_W(CRC_W), .POLY(CRC_POLY), .DATA_W(BYTE_W)) u_crc (
      .crc_in (crc_q),
      .data   (byte_data),
      .crc_out(crc_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pid_q <= '0;
         b1_q  <= '0;
         b2_q  <= '0;
         crc_q <= CRC_INIT;
      end else if (pkt_start) begin
         cnt_q <= '0;
         crc_q <= CRC_INIT;
      end else if (byte_valid) begin
         if (cnt_q == CNT_W'(0)) pid_q <= byte_data;
         if (cnt_q == CNT_W'(1)) b1_q  <= byte_data;
         if (cnt_q == CNT_W'(2)) b2_q  <= byte_data;
         if (cnt_q != CNT_W'(0) && cnt_q <= CNT_W'(FIELD_BYTES))
            crc_q <= crc_nx;
         if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // Verdict
   logic       pid_ok;
   pkt_class_e pid_cls;

   pid_classify u_pid (
      .pid_byte (pid_q),
      .pid_ok   (pid_ok),
      .pid_class(pid_cls)
   );

   logic       empty, has_crc, len_ok, e_pid, e_len, e_crc, clean;
   pkt_class_e cls_eff;

   always_comb begin
      empty   = (cnt_q == '0);
      cls_eff = empty ? CLS_NONE : pid_cls;
      has_crc = (cls_eff == CLS_TOKEN) || (cls_eff == CLS_FRAME);
      unique case (cls_eff)
         CLS_TOKEN, CLS_FRAME: len_ok = (cnt_q == CNT_W'(FULL_N));
         CLS_HSHAKE:           len_ok = (cnt_q == CNT_W'(1));
         default:              len_ok = 1'b1;
      endcase
      e_pid = !empty && !pid_ok;
      e_len = empty || (pid_ok && !len_ok);
      e_crc = has_crc && len_ok && (crc_q != CRC_RESIDUE);
      clean = !e_pid && !e_len && !e_crc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         err_pid   <= 1'b0;
         err_crc   <= 1'b0;
         err_len   <= 1'b0;
         dec_class <= '0;
         dec_pid   <= '0;
         dec_addr  <= '0;
         dec_endp  <= '0;
         dec_frame <= '0;
      end else if (pkt_end) begin
         dec_valid <= clean;
         err_pid   <= e_pid;
         err_crc   <= e_crc;
         err_len   <= e_len;
         dec_class <= cls_eff;
         dec_pid   <= pid_q[NIB_W-1:0];
         if (clean && cls_eff == CLS_TOKEN) begin
            dec_addr <= b1_q[ADDR_W-1:0];
            dec_endp <= {b2_q[ENDP_W-2:0], b1_q[BYTE_W-1]};
         end
         if (clean && cls_eff == CLS_FRAME)
            dec_frame <= {b2_q[HI_W-1:0], b1_q};
      end else begin
         dec_valid <= 1'b0;
         err_pid   <= 1'b0;
         err_crc   <= 1'b0;
         err_len   <= 1'b0;
      end
   end

   // Checks beside the verdict logic
   assert_valid_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_end |=> !dec_valid);
   assert_verdict_given_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |=> (dec_valid || err_pid || err_crc || err_len));
   assert_crc_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_crc |-> (dec_class == 3'd1 || dec_class == 3'd2));
   assert_pid_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_pid |-> (!err_crc && !err_len && dec_class == 3'd0));
   assert_len_no_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_len |-> !err_crc);
   assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_end |=> ($stable(dec_addr) && $stable(dec_frame)));
endmodule

// File: tb/pkt_token_decoder_test.sv
module pkt_token_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_start = 1'b0, byte_valid = 1'b0, pkt_end = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        dec_valid, err_pid, err_crc, err_len;
   logic [2:0]  dec_class;
   logic [3:0]  dec_pid, dec_endp;
   logic [6:0]  dec_addr;
   logic [10:0] dec_frame;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pkt_token_decoder uut (
      .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .byte_valid(byte_valid),
      .byte_data(byte_data), .pkt_end(pkt_end), .dec_valid(dec_valid),
      .dec_class(dec_class), .dec_pid(dec_pid), .dec_addr(dec_addr),
      .dec_endp(dec_endp), .dec_frame(dec_frame), .err_pid(err_pid),
      .err_crc(err_crc), .err_len(err_len)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // CRC register per R6
   function automatic logic [4:0] crc_run(input logic [15:0] bits);
      logic [4:0] r = 5'b11111;
      for (int i = 0; i < 16; i++) begin
         logic fb = bits[i] ^ r[4];
         r = {r[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
      end
      return r;
   endfunction

   function automatic logic [4:0] find_crc(input logic [10:0] field);
      for (int c = 0; c < 32; c++)
         if (crc_run({c[4:0], field}) == 5'b01100) return c[4:0];
      return 5'b00000;
   endfunction

   // payload bytes for an 11-bit field with correct CRC
   function automatic logic [15:0] payload(input logic [10:0] field);
      return {find_crc(field), field};
   endfunction

   task automatic send(input int n, input logic [7:0] b0, b1, b2, b3, b4);
      logic [7:0] bs [5];
      bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = b4;
      @(negedge clk); pkt_start = 1'b1;
      @(negedge clk); pkt_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         byte_valid = 1'b1; byte_data = bs[i];
         @(negedge clk);
      end
      byte_valid = 1'b0;
      pkt_end = 1'b1;
      @(negedge clk); pkt_end = 1'b0;
   endtask

   task automatic verdict(input string req, input int v, ep, ec, el, cls);
      chk(req, "dec_valid", dec_valid, v);
      chk(req, "err_pid", err_pid, ep);
      chk(req, "err_crc", err_crc, ec);
      chk(req, "err_len", err_len, el);
      if (cls >= 0) chk(req, "dec_class", dec_class, cls);
   endtask

   task automatic t_reset;
      chk("R1", "dec_valid", dec_valid, 0);
      chk("R1", "errors", {err_pid, err_crc, err_len}, 0);
      chk("R1", "dec_class", dec_class, 0);
      chk("R1", "fields", {dec_addr, dec_endp, dec_frame}, 0);
   endtask

   task automatic t_tokens;
      logic [15:0] p;
      p = payload({4'hA, 7'h55});
      send(3, 8'hE1, p[7:0], p[15:8], 0, 0);
      verdict("R4", 1, 0, 0, 0, 1);
      chk("R3", "dec_pid", dec_pid, 4'h1);
      chk("R4", "dec_addr", dec_addr, 7'h55);
      chk("R4", "dec_endp", dec_endp, 4'hA);
      @(negedge clk);
      chk("R9", "pulse width", dec_valid, 0);
      p = payload({4'h3, 7'h7F});
      send(3, 8'h69, p[7:0], p[15:8], 0, 0);
      verdict("R4", 1, 0, 0, 0, 1);
      chk("R4", "IN addr", dec_addr, 7'h7F);
      chk("R4", "IN endp", dec_endp, 4'h3);
      p = payload({4'hF, 7'h00});
      send(3, 8'h2D, p[7:0], p[15:8], 0, 0);
      verdict("R3", 1, 0, 0, 0, 1);
      chk("R3", "SETUP pid", dec_pid, 4'hD);
      chk("R4", "SETUP endp", dec_endp, 4'hF);
   endtask

   task automatic t_frames;
      logic [15:0] p;
      p = payload(11'h5A3);
      send(3, 8'hA5, p[7:0], p[15:8], 0, 0);
      verdict("R5", 1, 0, 0, 0, 2);
      chk("R5", "dec_frame", dec_frame, 11'h5A3);
      p = payload(11'h7FF);
      send(3, 8'hA5, p[7:0], p[15:8], 0, 0);
      verdict("R5", 1, 0, 0, 0, 2);
      chk("R5", "dec_frame max", dec_frame, 11'h7FF);
   endtask

   task automatic t_crc_bad;
      logic [15:0] p;
      p = payload({4'h1, 7'h12});
      send(3, 8'hE1, p[7:0], p[15:8] ^ 8'h08, 0, 0);
      verdict("R6", 0, 0, 1, 0, 1);
      chk("R11", "addr kept", dec_addr, 7'h00);
      p = payload(11'h001);
      send(3, 8'hA5, p[7:0] ^ 8'h01, p[15:8], 0, 0);
      verdict("R6", 0, 0, 1, 0, 2);
      chk("R11", "frame kept", dec_frame, 11'h7FF);
   endtask

   task automatic t_pid_bad;
      send(1, 8'hE0, 0, 0, 0, 0);
      verdict("R2", 0, 1, 0, 0, 0);
      send(3, 8'h61, 8'h00, 8'h00, 0, 0);
      verdict("R2", 0, 1, 0, 0, 0);
      send(1, 8'hF0, 0, 0, 0, 0);
      verdict("R3", 0, 1, 0, 0, 0);
   endtask

   task automatic t_length;
      logic [15:0] p;
      p = payload({4'h2, 7'h22});
      send(2, 8'hE1, p[7:0], 0, 0, 0);
      verdict("R7", 0, 0, 0, 1, 1);
      send(4, 8'hE1, p[7:0], p[15:8], 8'h00, 0);
      verdict("R7", 0, 0, 0, 1, 1);
      send(1, 8'hA5, 0, 0, 0, 0);
      verdict("R7", 0, 0, 0, 1, 2);
      chk("R11", "addr kept", dec_addr, 7'h00);
      send(1, 8'hD2, 0, 0, 0, 0);
      verdict("R8", 1, 0, 0, 0, 4);
      send(2, 8'h5A, 8'h00, 0, 0, 0);
      verdict("R8", 0, 0, 0, 1, 4);
      send(1, 8'h1E, 0, 0, 0, 0);
      verdict("R8", 1, 0, 0, 0, 4);
      send(0, 0, 0, 0, 0, 0);
      verdict("R8", 0, 0, 0, 1, 0);
   endtask

   task automatic t_data;
      logic [6:0] a_before;
      logic [3:0] e_before;
      logic [10:0] f_before;
      a_before = dec_addr; e_before = dec_endp; f_before = dec_frame;
      send(5, 8'hC3, 8'h11, 8'h22, 8'h33, 8'h44);
      verdict("R10", 1, 0, 0, 0, 3);
      chk("R10", "DATA0 pid", dec_pid, 4'h3);
      send(1, 8'h4B, 0, 0, 0, 0);
      verdict("R10", 1, 0, 0, 0, 3);
      send(3, 8'h3C, 8'hFF, 8'hFF, 0, 0);
      verdict("R10", 1, 0, 0, 0, 5);
      chk("R11", "addr held", dec_addr, a_before);
      chk("R11", "endp held", dec_endp, e_before);
      chk("R11", "frame held", dec_frame, f_before);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_crc_bad_first();
            t_tokens();
            t_frames();
            t_crc_bad();
            t_pid_bad();
            t_length();
            t_data();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // a wrong-CRC token before any clean token leaves the reset fields untouched
   task automatic t_crc_bad_first;
      logic [15:0] p;
      p = payload({4'h6, 7'h33});
      send(3, 8'hE1, p[7:0], p[15:8] ^ 8'h80, 0, 0);
      verdict("R6", 0, 0, 1, 0, 1);
      chk("R11", "endp kept", dec_endp, 0);
   endtask
endmodule